// File: doc/BRIEF.md
# Register Move Shift and Negate Unit

This unit executes the two move instructions of a 16-bit processor core. A register move takes the value read from the source register, passes it through a barrel shifter that shifts left or right, logically or arithmetically, by 0 to 15 positions, and then optionally takes the two's complement of the shifted value. An immediate move builds its value from the 8-bit immediate in the instruction word. That value can be placed in the high byte and can be negated.

The instruction word and the source register value are presented each cycle. One clock edge later the unit presents the destination register index, the result and a write enable for the register file. Instructions that are not moves produce no write. The register file and the flags are outside the unit, and the unit never touches the flags.

Top module: `mvu_top`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is asserted, `wr_en`, `rd_idx` and `mv_result` are all zero.
- R2: Opcode `instr[15:12]` = 4'b0110 is a register move and 4'b0111 is an immediate move. For either one, the edge after the instruction is presented sets `wr_en` to 1 and `rd_idx` to `instr[11:10]`.
- R3: For any other opcode, the following edge drives `wr_en`, `rd_idx` and `mv_result` to zero.
- R4: For a register move, `instr[3:0]` is the shift distance and `instr[6]` is the direction (0 = left, 1 = right). A left shift fills with zeros. A logical right shift (`instr[5]` = 0) fills with zeros.
- R5: `instr[5]` = 1 selects an arithmetic shift. Right shifts then fill with the sign bit of `rs_val`, and left shifts give the same result as a logical left shift.
- R6: For a register move, `instr[7]` = 1 replaces the shifted value with its two's complement (invert all bits, add 1). The negate is applied after the shift, so 0x8000 negates to 0x8000 and 0 negates to 0.
- R7: A register move with a shift distance of 0 and `instr[7]` = 0 writes `rs_val` unchanged.
- R8: An immediate move zero-extends `instr[7:0]`. `instr[8]` = 1 moves it into bits 15:8 with bits 7:0 zero. `instr[9]` = 1 negates that value last.
- R9: `instr[4]` has no effect on a register move, and `rs_val` has no effect on an immediate move.
- R10: A new instruction is accepted every cycle, and each result appears exactly one edge after its instruction, with no interaction between neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word |
| rs_val | input | DATA_W | Value of the source register |
| wr_en | output | 1 | Register file write enable |
| rd_idx | output | 2 | Destination register index |
| mv_result | output | DATA_W | Value to write |

## Verification
The bench builds the unit with its default 16-bit data width. This makes the 4-bit shift field cover every possible shift distance, so a walk over all 16 distances, in every direction and kind, with and without negation, reaches each barrel stage in every combination. With 16 bits the high-byte placement fills the whole upper half, so the negation of 0x8000 and the sign fill across the full word are both reachable. A long stream of mixed opcodes then drives back-to-back instructions against a behavioural model.

// File: rtl/mvu_pkg.sv
package mvu_pkg;

    // Instruction encoding: fixed by the instruction set
    localparam int INSTR_W   = 16;
    localparam int OPC_HI    = 15;
    localparam int OPC_LO    = 12;
    localparam int RD_HI     = 11;
    localparam int RD_LO     = 10;
    localparam int SH_W      = 4;
    localparam int IMM_W     = 8;
    localparam int BIT_RNEG  = 7;
    localparam int BIT_RIGHT = 6;
    localparam int BIT_ARITH = 5;
    localparam int BIT_INEG  = 9;
    localparam int BIT_HIGH  = 8;

    localparam logic [3:0] OPC_MOV_REG = 4'b0110;
    localparam logic [3:0] OPC_MOV_IMM = 4'b0111;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_REG  = 2'd1,
        MV_IMM  = 2'd2
    } mv_kind_e;

    typedef struct packed {
        mv_kind_e          kind;
        logic [1:0]        rd;
        logic              negate;
        logic              right;
        logic              arith;
        logic [SH_W-1:0]   shamt;
        logic              high;
        logic [IMM_W-1:0]  imm;
    } mv_ctrl_t;

    function automatic mv_ctrl_t decode_mv(input logic [INSTR_W-1:0] iw);
        mv_ctrl_t c;
        c.rd     = iw[RD_HI:RD_LO];
        c.shamt  = iw[SH_W-1:0];
        c.imm    = iw[IMM_W-1:0];
        c.right  = iw[BIT_RIGHT];
        c.arith  = iw[BIT_ARITH];
        c.high   = iw[BIT_HIGH];
        unique case (iw[OPC_HI:OPC_LO])
            OPC_MOV_REG: begin
                c.kind   = MV_REG;
                c.negate = iw[BIT_RNEG];
            end
            OPC_MOV_IMM: begin
                c.kind   = MV_IMM;
                c.negate = iw[BIT_INEG];
            end
            default: begin
                c.kind   = MV_NONE;
                c.negate = 1'b0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mvu_shifter.sv
module mvu_shifter #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 4
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  logic              right,
    input  logic              arith,
    output logic [DATA_W-1:0] dout
);
    logic                          fill;
    logic [AMT_W:0][DATA_W-1:0]    stg;

    assign fill   = right & arith & din[DATA_W-1];
    assign stg[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        logic [DATA_W-1:0] shl;
        logic [DATA_W-1:0] shr;
        assign shl = {stg[k][DATA_W-1-DIST:0], {DIST{1'b0}}};
        assign shr = {{DIST{fill}}, stg[k][DATA_W-1:DIST]};
        assign stg[k+1] = !amt[k] ? stg[k] : (right ? shr : shl);
    end

    assign dout = stg[AMT_W];
endmodule

// File: rtl/mvu_immgen.sv
module mvu_immgen #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              high,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] ext;

    assign ext  = DATA_W'(imm);
    assign dout = high ? (ext << IMM_W) : ext;
endmodule

// File: rtl/mvu_negate.sv
module mvu_negate #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  logic              en,
    output logic [DATA_W-1:0] dout
);
    assign dout = en ? (~din + DATA_W'(1)) : din;
endmodule

// File: rtl/mvu_top.sv
module mvu_top import mvu_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rs_val,
    output logic               wr_en,
    output logic [1:0]         rd_idx,
    output logic [DATA_W-1:0]  mv_result
);
    mv_ctrl_t          ctl;
    logic [DATA_W-1:0] sh_val;
    logic [DATA_W-1:0] imm_val;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] fin_val;

    assign ctl = decode_mv(instr);

    mvu_shifter #(.DATA_W(DATA_W), .AMT_W(SH_W)) u_shift (
        .din   (rs_val),
        .amt   (ctl.shamt),
        .right (ctl.right),
        .arith (ctl.arith),
        .dout  (sh_val)
    );

    mvu_immgen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
        .imm  (ctl.imm),
        .high (ctl.high),
        .dout (imm_val)
    );

    assign src_val = (ctl.kind == MV_IMM) ? imm_val : sh_val;

    mvu_negate #(.DATA_W(DATA_W)) u_neg (
        .din  (src_val),
        .en   (ctl.negate),
        .dout (fin_val)
    );

    always_ff @(posedge clk) begin
        if (rst || ctl.kind == MV_NONE) begin
            wr_en     <= 1'b0;
            rd_idx    <= '0;
            mv_result <= '0;
        end else begin
            wr_en     <= 1'b1;
            rd_idx    <= ctl.rd;
            mv_result <= fin_val;
        end
    end
endmodule

// File: rtl/mvu_checker.sv
module mvu_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       instr,
    input logic [DATA_W-1:0] rs_val,
    input logic              wr_en,
    input logic [1:0]        rd_idx,
    input logic [DATA_W-1:0] mv_result
);
    logic is_move;
    assign is_move = (instr[15:12] == 4'b0110) || (instr[15:12] == 4'b0111);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!wr_en && rd_idx == 2'd0 && mv_result == '0));

    // R2
    move_write_chk: assert property (@(posedge clk) disable iff (rst)
        is_move |=> (wr_en && rd_idx == $past(instr[11:10])));

    // R3
    other_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !is_move |=> (!wr_en && rd_idx == 2'd0 && mv_result == '0));

    // R4
    lsr_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'b0110 && !instr[7] && instr[6] && !instr[5] && instr[3:0] != 4'd0)
        |=> !mv_result[DATA_W-1]);

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'b0110 && !instr[7] && instr[3:0] == 4'd0)
        |=> mv_result == $past(rs_val));

    // R8
    imm_low_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'b0111 && !instr[9] && !instr[8])
        |=> mv_result == DATA_W'($past(instr[7:0])));

    // R8
    imm_high_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[15:12] == 4'b0111 && instr[8]) |=> mv_result[7:0] == 8'h00);
endmodule

bind mvu_top mvu_checker #(.DATA_W(DATA_W)) u_mvu_checker (
    .clk       (clk),
    .rst       (rst),
    .instr     (instr),
    .rs_val    (rs_val),
    .wr_en     (wr_en),
    .rd_idx    (rd_idx),
    .mv_result (mv_result)
);

// File: tb/test_mvu_top.sv
module test_mvu_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] instr;
    logic [15:0] rs_val;
    logic        wr_en;
    logic [1:0]  rd_idx;
    logic [15:0] mv_result;

    int checks = 0;
    int fails  = 0;

    bit          pend_ok = 1'b0;
    bit          exp_we;
    logic [1:0]  exp_rd;
    logic [15:0] exp_res;
    string       exp_tag;

    always #4 clk = ~clk;

    mvu_top #(.DATA_W(16)) i_mvu_top (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .rs_val    (rs_val),
        .wr_en     (wr_en),
        .rd_idx    (rd_idx),
        .mv_result (mv_result)
    );

    function automatic void model(input logic [15:0] iw, input logic [15:0] rs,
                                  output bit we, output logic [1:0] rd,
                                  output logic [15:0] res);
        logic [15:0] v;
        int sh;
        we = 1'b0; rd = 2'd0; res = 16'h0000;
        if (iw[15:12] == 4'd6) begin
            sh = int'(iw[3:0]);
            if (!iw[6])      v = rs << sh;
            else if (iw[5])  v = 16'($signed(rs) >>> sh);
            else             v = rs >> sh;
            if (iw[7]) v = 16'(0) - v;
            we = 1'b1; rd = iw[11:10]; res = v;
        end else if (iw[15:12] == 4'd7) begin
            v = {8'h00, iw[7:0]};
            if (iw[8]) v = {iw[7:0], 8'h00};
            if (iw[9]) v = 16'(0) - v;
            we = 1'b1; rd = iw[11:10]; res = v;
        end
    endfunction

    function automatic string auto_tag(input logic [15:0] iw);
        if (iw[15:12] == 4'd7) return "R8";
        if (iw[15:12] != 4'd6) return "R3";
        if (iw[7])             return "R6";
        if (iw[3:0] == 4'd0)   return "R7";
        if (iw[5] && iw[6])    return "R5";
        return "R4";
    endfunction

    task automatic compare();
        if (!pend_ok) return;
        checks++;
        if (wr_en !== exp_we || rd_idx !== exp_rd || mv_result !== exp_res) begin
            fails++;
            $display("FAIL %s: got we=%0b rd=%0d res=%h, expected we=%0b rd=%0d res=%h",
                     exp_tag, wr_en, rd_idx, mv_result, exp_we, exp_rd, exp_res);
        end
    endtask

    task automatic step(input logic [15:0] iw, input logic [15:0] rs, input string tag);
        @(negedge clk);
        compare();
        instr  = iw;
        rs_val = rs;
        model(iw, rs, exp_we, exp_rd, exp_res);
        exp_tag = (tag == "") ? auto_tag(iw) : tag;
        pend_ok = 1'b1;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no completion, expected end of run");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        instr  = 16'h7DFF;
        rs_val = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: move presented during reset must not appear
        checks++;
        if (wr_en !== 1'b0 || rd_idx !== 2'd0 || mv_result !== 16'h0) begin
            fails++;
            $display("FAIL R1: got we=%0b rd=%0d res=%h, expected we=0 rd=0 res=0000",
                     wr_en, rd_idx, mv_result);
        end
        model(instr, rs_val, exp_we, exp_rd, exp_res);
        exp_tag = "R1";
        rst     = 1'b0;
        pend_ok = 1'b1;

        // R4 R5 R6: every distance, direction, kind, with and without negate
        for (int n = 0; n < 2; n++)
            for (int d = 0; d < 2; d++)
                for (int a = 0; a < 2; a++)
                    for (int s = 0; s < 16; s++)
                        step({4'd6, 2'(s), 2'd1, 1'(n), 1'(d), 1'(a), 1'b0, 4'(s)},
                             (s % 2 == 0) ? 16'h8001 : 16'h4B3C, "");

        // R6: negate corners
        step(16'h6080, 16'h8000, "R6");
        step(16'h6080, 16'h0000, "R6");
        step(16'h60C1, 16'h0001, "R6");

        // R8: immediate forms
        for (int k = 0; k < 4; k++) begin
            step({4'd7, 2'd2, 2'(k), 8'h00}, 16'hAAAA, "R8");
            step({4'd7, 2'd1, 2'(k), 8'hFF}, 16'h5555, "R8");
            step({4'd7, 2'd3, 2'(k), 8'h80}, 16'h1234, "R8");
        end

        // R9: bit 4 ignored on register move; rs ignored on immediate move
        step(16'h6573, 16'hC0DE, "R9");
        step(16'h6563, 16'hC0DE, "R9");
        step(16'h7A5A, 16'h0000, "R9");
        step(16'h7A5A, 16'hFFFF, "R9");

        // R3: every non-move opcode
        for (int o = 0; o < 16; o++)
            if (o != 6 && o != 7) step({4'(o), 12'hFFF}, 16'hFFFF, "R3");

        // R2: destination index for each register
        for (int r = 0; r < 4; r++) step({4'd6, 2'(r), 10'h000}, 16'h0F0F, "R2");

        // R10: back-to-back mixed stream
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] iw;
            iw = 16'($urandom);
            if (i % 3 == 0) iw[15:12] = 4'd6;
            else if (i % 3 == 1) iw[15:12] = 4'd7;
            step(iw, 16'($urandom), "");
        end

        @(negedge clk);
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule